// File: doc/BRIEF.md
# Quasi-Resonant Off-Time Sequencer

This block produces the gate-drive enable of a quasi-resonant flyback converter. It works in a single clock domain. Its inputs are comparator results that have already been digitised: a valley flag, a current-sense trip flag and an unsigned feedback code. Each switching period has an on phase and an off phase. The on phase ends when an unblanked current-sense trip arrives, or when the on-time cap is reached. The off phase begins with a minimum off-time, which gets longer as the feedback code falls. When the minimum off-time expires, a valley-search window opens. The next on phase starts a short fixed delay after the first valley seen in that window. If no valley comes before the window times out, the next on phase starts anyway.

Two timing sets are built in, one for low-frequency operation and one for high-frequency operation. A select input picks one of them, and it is read only while reset is held. The feedback code has an upper knee and a lower knee, both set by parameters. At or above the upper knee the minimum off-time is at its floor. Below the upper knee the block is in light-load operation, and the off-time grows as a shifted (multiply-free) ramp. The ramp is capped at the lower knee. Light-load entry has a hysteresis band. A fault input pulls the gate low at once and holds the sequence in its off phase. When the fault is released, the sequence starts again with a full minimum off-time.

Top module: `qrs_sequencer`

## Requirements
- R1: While reset is held, `gateOut` is 0 and the timing set is taken from `hfSelIn` (0 = low-frequency, 1 = high-frequency). Changes on `hfSelIn` after reset have no effect on any interval.
- R2: With light-load mode inactive, the minimum off-time is the selected set's floor (`LF_OFF_MIN` or `HF_OFF_MIN` cycles). After the gate falls, the valley-search window opens only once that many cycles have passed.
- R3: With light-load mode active, the minimum off-time is latched when the gate falls. It equals min(floor + ((`HI_KNEE` − fbCode) << shift), ceiling). It equals the ceiling (`LF_OFF_MAX`/`HF_OFF_MAX`) whenever fbCode ≤ `LO_KNEE`.
- R4: Light-load mode is entered when fbCode < `HI_KNEE` − `GREEN_HYST`. It is left when fbCode ≥ `HI_KNEE`. Between those levels it keeps its previous state.
- R5: `valleyIn` has no effect while the gate is on, and none during the minimum off-time.
- R6: If no valley is seen in the search window, the gate rises after the window has been open for the set's timeout (`LF_TIMEOUT`/`HF_TIMEOUT` cycles). With no valley, the low time is therefore off-time + timeout.
- R7: A valley that is sampled in the search window raises the gate `VALLEY_DLY`+1 cycles later. With the valley held high, the low time is off-time + `VALLEY_DLY` + 1.
- R8: For the first `BLANK_CYC` cycles of the on phase, `csTripIn` is masked. A trip sampled in on-cycle k ≥ `BLANK_CYC` (the first on-cycle is 0) gives a pulse of k+1 cycles.
- R9: With no trip, the gate stays high for exactly `ON_MAX_CYC` cycles.
- R10: `faultIn` drives `gateOut` low in the same cycle and keeps it low. After release, the gate stays low for the full minimum off-time, computed from the feedback level at that point, counted from the release and followed by the search window.
- R11: With the high-frequency set selected, the `HF_*` floor, ceiling, timeout and shift apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; timing set sampled while high |
| hfSelIn | input | 1 | Timing-set select: 0 low-frequency, 1 high-frequency |
| fbCode | input | FB_W | Feedback level as an unsigned code |
| valleyIn | input | 1 | Valley detected (digitised comparator) |
| csTripIn | input | 1 | Current-sense threshold reached |
| faultIn | input | 1 | Forces the gate low and holds the sequence off |
| gateOut | output | 1 | Gate-drive enable |

## Verification
The off interval is measured in four situations: valley held high, valley absent, valley pulsed only inside the minimum off-time, and valley held high across the on phase. Together they separate the delayed-valley path, the timeout path and the masking of early or on-phase valleys. Feedback codes above the upper knee, on the ramp, below the lower knee, and between the clamp point and the lower knee show the floor, the slope and both clamps. The ones inside the hysteresis band are approached from both sides, so they show whether state is kept. The pulse width is measured with the trip held high, with the trip arriving late, and with no trip at all, which separates blanking, trip termination and the on-time cap. A fault held across a change of feedback level, and a second reset with the other timing set, cover the restart behaviour and the variant choice.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SEARCH = 2'd1,
    ST_ARM    = 2'd2,
    ST_ON     = 2'd3
  } seqStateT;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic latchOff;
  } seqStrobeT;

  // datapath -> control timer flags
  typedef struct packed {
    logic offDone;
    logic searchExpired;
    logic blankOver;
    logic onMaxHit;
    logic dlyDone;
  } tmrFlagsT;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qrs_timing_dp.sv
module qrs_timing_dp
  import qrs_pkg::*;
#(
  parameter int FB_W        = 8,
  parameter int CNT_W       = 13,
  parameter int LF_OFF_MIN  = 800,
  parameter int LF_OFF_MAX  = 3800,
  parameter int LF_TIMEOUT  = 900,
  parameter int LF_SHIFT    = 6,
  parameter int HF_OFF_MIN  = 300,
  parameter int HF_OFF_MAX  = 1300,
  parameter int HF_TIMEOUT  = 500,
  parameter int HF_SHIFT    = 4,
  parameter int HI_KNEE     = 107,
  parameter int LO_KNEE     = 61,
  parameter int GREEN_HYST  = 5,
  parameter int BLANK_CYC   = 63,
  parameter int ON_MAX_CYC  = 4500,
  parameter int VALLEY_DLY  = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hfSelIn,
  input  logic [FB_W-1:0] fbCode,
  input  seqStrobeT       strb,
  output tmrFlagsT        flags
);

  localparam int RAMP_W = CNT_W + FB_W + 1;
  localparam logic [FB_W-1:0] KNEE_HI  = FB_W'(HI_KNEE);
  localparam logic [FB_W-1:0] KNEE_LO  = FB_W'(LO_KNEE);
  localparam logic [FB_W-1:0] GREEN_ON = FB_W'(HI_KNEE - GREEN_HYST);
  localparam int NUM_VAR = 2;

  logic             useHf;
  logic             greenMode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] offTarget;
  logic [CNT_W-1:0] nextOff;
  logic [CNT_W-1:0] searchLen;
  logic [FB_W-1:0]  kneeGap;
  logic [CNT_W-1:0] varTarget [NUM_VAR];
  logic [CNT_W-1:0] varTimeout [NUM_VAR];

  // timing-set choice, taken only while reset is held
  always_ff @(posedge clk) begin
    if (rst) useHf <= hfSelIn;
  end

  // light-load mode with hysteresis
  always_ff @(posedge clk) begin
    if (rst)                   greenMode <= 1'b0;
    else if (fbCode >= KNEE_HI)  greenMode <= 1'b0;
    else if (fbCode < GREEN_ON)  greenMode <= 1'b1;
  end

  assign kneeGap = (fbCode < KNEE_HI) ? (KNEE_HI - fbCode) : '0;

  // one off-time ramp per timing set
  for (genvar v = 0; v < NUM_VAR; v++) begin : g_var
    localparam int VMIN   = (v == 0) ? LF_OFF_MIN : HF_OFF_MIN;
    localparam int VMAX   = (v == 0) ? LF_OFF_MAX : HF_OFF_MAX;
    localparam int VTO    = (v == 0) ? LF_TIMEOUT : HF_TIMEOUT;
    localparam int VSHIFT = (v == 0) ? LF_SHIFT   : HF_SHIFT;

    logic [RAMP_W-1:0] ramp;

    assign ramp = RAMP_W'(VMIN) + (RAMP_W'(kneeGap) << VSHIFT);

    always_comb begin
      if (!greenMode)
        varTarget[v] = CNT_W'(VMIN);
      else if (fbCode <= KNEE_LO)
        varTarget[v] = CNT_W'(VMAX);
      else if (ramp > RAMP_W'(VMAX))
        varTarget[v] = CNT_W'(VMAX);
      else
        varTarget[v] = ramp[CNT_W-1:0];
    end

    assign varTimeout[v] = CNT_W'(VTO);
  end

  assign nextOff   = useHf ? varTarget[1]  : varTarget[0];
  assign searchLen = useHf ? varTimeout[1] : varTimeout[0];

  // off-time latched at gate fall (or each fault cycle)
  always_ff @(posedge clk) begin
    if (rst)
      offTarget <= hfSelIn ? CNT_W'(HF_OFF_MIN) : CNT_W'(LF_OFF_MIN);
    else if (strb.latchOff)
      offTarget <= nextOff;
  end

  // shared phase counter, saturating
  always_ff @(posedge clk) begin
    if (rst || strb.clrCnt) cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + CNT_W'(1);
  end

  assign flags.offDone       = (cnt == offTarget - CNT_W'(1));
  assign flags.searchExpired = (cnt == searchLen - CNT_W'(1));
  assign flags.blankOver     = (cnt >= CNT_W'(BLANK_CYC));
  assign flags.onMaxHit      = (cnt == CNT_W'(ON_MAX_CYC - 1));
  assign flags.dlyDone       = (cnt == CNT_W'(VALLEY_DLY - 1));

endmodule

// File: rtl/qrs_seq_ctrl.sv
module qrs_seq_ctrl
  import qrs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      valleyIn,
  input  logic      csTripIn,
  input  logic      faultIn,
  input  tmrFlagsT  flags,
  output seqStrobeT strb,
  output logic      gateOn
);

  seqStateT state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nextState;
  end

  always_comb begin
    nextState     = state;
    strb.clrCnt   = 1'b0;
    strb.latchOff = 1'b0;
    if (faultIn) begin
      nextState     = ST_OFF;
      strb.clrCnt   = 1'b1;
      strb.latchOff = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (flags.offDone) begin
            nextState   = ST_SEARCH;
            strb.clrCnt = 1'b1;
          end
        end
        ST_SEARCH: begin
          if (valleyIn) begin
            nextState   = ST_ARM;
            strb.clrCnt = 1'b1;
          end else if (flags.searchExpired) begin
            nextState   = ST_ON;
            strb.clrCnt = 1'b1;
          end
        end
        ST_ARM: begin
          if (flags.dlyDone) begin
            nextState   = ST_ON;
            strb.clrCnt = 1'b1;
          end
        end
        ST_ON: begin
          if (flags.onMaxHit || (csTripIn && flags.blankOver)) begin
            nextState     = ST_OFF;
            strb.clrCnt   = 1'b1;
            strb.latchOff = 1'b1;
          end
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  assign gateOn = (state == ST_ON);

endmodule

// File: rtl/qrs_sequencer.sv
module qrs_sequencer
  import qrs_pkg::*;
#(
  parameter int FB_W        = 8,
  parameter int LF_OFF_MIN  = 800,
  parameter int LF_OFF_MAX  = 3800,
  parameter int LF_TIMEOUT  = 900,
  parameter int LF_SHIFT    = 6,
  parameter int HF_OFF_MIN  = 300,
  parameter int HF_OFF_MAX  = 1300,
  parameter int HF_TIMEOUT  = 500,
  parameter int HF_SHIFT    = 4,
  parameter int HI_KNEE     = 107,
  parameter int LO_KNEE     = 61,
  parameter int GREEN_HYST  = 5,
  parameter int BLANK_CYC   = 63,
  parameter int ON_MAX_CYC  = 4500,
  parameter int VALLEY_DLY  = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hfSelIn,
  input  logic [FB_W-1:0] fbCode,
  input  logic            valleyIn,
  input  logic            csTripIn,
  input  logic            faultIn,
  output logic            gateOut
);

  localparam int LONGEST = maxInt(maxInt(LF_OFF_MAX, HF_OFF_MAX),
                                  maxInt(maxInt(LF_TIMEOUT, HF_TIMEOUT),
                                         maxInt(ON_MAX_CYC, maxInt(BLANK_CYC, VALLEY_DLY))));
  localparam int CNT_W = $clog2(LONGEST + 1);

  seqStrobeT strb;
  tmrFlagsT  flags;
  logic      gateOn;

  qrs_timing_dp #(
    .FB_W(FB_W), .CNT_W(CNT_W),
    .LF_OFF_MIN(LF_OFF_MIN), .LF_OFF_MAX(LF_OFF_MAX), .LF_TIMEOUT(LF_TIMEOUT), .LF_SHIFT(LF_SHIFT),
    .HF_OFF_MIN(HF_OFF_MIN), .HF_OFF_MAX(HF_OFF_MAX), .HF_TIMEOUT(HF_TIMEOUT), .HF_SHIFT(HF_SHIFT),
    .HI_KNEE(HI_KNEE), .LO_KNEE(LO_KNEE), .GREEN_HYST(GREEN_HYST),
    .BLANK_CYC(BLANK_CYC), .ON_MAX_CYC(ON_MAX_CYC), .VALLEY_DLY(VALLEY_DLY)
  ) u_dp (
    .clk(clk), .rst(rst), .hfSelIn(hfSelIn), .fbCode(fbCode),
    .strb(strb), .flags(flags)
  );

  qrs_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .valleyIn(valleyIn), .csTripIn(csTripIn),
    .faultIn(faultIn), .flags(flags), .strb(strb), .gateOn(gateOn)
  );

  // fault acts without waiting for the next clock edge
  assign gateOut = gateOn & ~faultIn;

endmodule

// File: rtl/qrs_sequencer_chk.sv
module qrs_sequencer_chk #(
  parameter int LF_OFF_MIN  = 800,
  parameter int LF_OFF_MAX  = 3800,
  parameter int LF_TIMEOUT  = 900,
  parameter int HF_OFF_MIN  = 300,
  parameter int HF_OFF_MAX  = 1300,
  parameter int HF_TIMEOUT  = 500,
  parameter int BLANK_CYC   = 63,
  parameter int ON_MAX_CYC  = 4500
) (
  input logic clk,
  input logic rst,
  input logic hfSelIn,
  input logic faultIn,
  input logic gateOut
);

  logic varHf;
  int   lowRun;
  int   highRun;
  int   offFloor;
  int   lowBound;

  always_ff @(posedge clk) begin
    if (rst) begin
      varHf   <= hfSelIn;
      lowRun  <= 0;
      highRun <= 0;
    end else begin
      lowRun  <= (gateOut || faultIn) ? 0 : lowRun + 1;
      highRun <= gateOut ? highRun + 1 : 0;
    end
  end

  assign offFloor = varHf ? HF_OFF_MIN : LF_OFF_MIN;
  assign lowBound = varHf ? (HF_OFF_MAX + HF_TIMEOUT) : (LF_OFF_MAX + LF_TIMEOUT);

  // R10: fault keeps the gate low
  a_r10_fault_gate_low: assert property (@(posedge clk) disable iff (rst)
    faultIn |-> !gateOut);

  // R2: a rise never comes before the minimum off-time floor
  a_r2_min_off_floor: assert property (@(posedge clk) disable iff (rst)
    $rose(gateOut) |-> (lowRun >= offFloor));

  // R6: low phase bounded by ceiling plus search timeout
  a_r6_low_bounded: assert property (@(posedge clk) disable iff (rst)
    lowRun <= lowBound);

  // R9: on-time cap
  a_r9_on_capped: assert property (@(posedge clk) disable iff (rst)
    gateOut |-> (highRun < ON_MAX_CYC));

  // R8: no pulse shorter than the blanking window unless faulted
  a_r8_blank_respected: assert property (@(posedge clk) disable iff (rst)
    ($fell(gateOut) && !faultIn) |-> (highRun >= BLANK_CYC + 1));

endmodule

bind qrs_sequencer qrs_sequencer_chk #(
  .LF_OFF_MIN(LF_OFF_MIN), .LF_OFF_MAX(LF_OFF_MAX), .LF_TIMEOUT(LF_TIMEOUT),
  .HF_OFF_MIN(HF_OFF_MIN), .HF_OFF_MAX(HF_OFF_MAX), .HF_TIMEOUT(HF_TIMEOUT),
  .BLANK_CYC(BLANK_CYC), .ON_MAX_CYC(ON_MAX_CYC)
) u_chk (
  .clk(clk), .rst(rst), .hfSelIn(hfSelIn), .faultIn(faultIn), .gateOut(gateOut)
);

// File: tb/qrs_sequencer_tb.sv
module qrs_sequencer_tb;

  localparam int LF_MIN = 20, LF_MAX = 80, LF_TO = 30, LF_SH = 1;
  localparam int HF_MIN = 10, HF_MAX = 40, HF_TO = 15, HF_SH = 0;
  localparam int HI = 100, LO = 60, HYST = 4;
  localparam int BLANK = 6, ONMAX = 100, VDLY = 3;
  localparam int WAIT_LIMIT = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hfSelIn = 1'b0;
  logic [7:0] fbCode = 8'd120;
  logic       valleyIn = 1'b0;
  logic       csTripIn = 1'b0;
  logic       faultIn = 1'b0;
  logic       gateOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  qrs_sequencer #(
    .FB_W(8),
    .LF_OFF_MIN(LF_MIN), .LF_OFF_MAX(LF_MAX), .LF_TIMEOUT(LF_TO), .LF_SHIFT(LF_SH),
    .HF_OFF_MIN(HF_MIN), .HF_OFF_MAX(HF_MAX), .HF_TIMEOUT(HF_TO), .HF_SHIFT(HF_SH),
    .HI_KNEE(HI), .LO_KNEE(LO), .GREEN_HYST(HYST),
    .BLANK_CYC(BLANK), .ON_MAX_CYC(ONMAX), .VALLEY_DLY(VDLY)
  ) u_dut (
    .clk(clk), .rst(rst), .hfSelIn(hfSelIn), .fbCode(fbCode),
    .valleyIn(valleyIn), .csTripIn(csTripIn), .faultIn(faultIn), .gateOut(gateOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitLevel(input logic lvl);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (gateOut !== lvl && n < WAIT_LIMIT);
    if (n >= WAIT_LIMIT) check("wait-gate", 0, 1);
  endtask

  // low cycles of one off phase, counted at negedges
  task automatic measLow(output int n);
    waitLevel(1'b1);
    waitLevel(1'b0);
    n = 1;
    forever begin
      @(negedge clk);
      if (gateOut !== 1'b0 || n >= WAIT_LIMIT) break;
      n++;
    end
  endtask

  task automatic measHigh(output int n);
    waitLevel(1'b0);
    waitLevel(1'b1);
    n = 1;
    forever begin
      @(negedge clk);
      if (gateOut !== 1'b1 || n >= WAIT_LIMIT) break;
      n++;
    end
  endtask

  task automatic lowAfterSettle(output int n);
    int dummy;
    measLow(dummy);
    measLow(n);
  endtask

  task automatic doReset(input logic sel);
    rst = 1'b1;
    hfSelIn = sel;
    repeat (4) @(negedge clk);
    check("R1 gate low in reset", int'(gateOut), 0);
    rst = 1'b0;
  endtask

  task automatic testFloorAndValley();
    int n;
    fbCode = 8'd120; valleyIn = 1'b1; csTripIn = 1'b0;
    lowAfterSettle(n);
    check("R2 R7 floor off with valley held", n, LF_MIN + VDLY + 1);
    measHigh(n);
    check("R9 R5 max on-time, valley held during on", n, ONMAX);
  endtask

  task automatic testTimeout();
    int n;
    fbCode = 8'd120; valleyIn = 1'b0;
    lowAfterSettle(n);
    check("R6 timeout restart", n, LF_MIN + LF_TO);
  endtask

  task automatic testEarlyValley();
    int n;
    valleyIn = 1'b0;
    waitLevel(1'b1);
    waitLevel(1'b0);
    n = 1;
    forever begin
      @(negedge clk);
      if (gateOut !== 1'b0 || n >= WAIT_LIMIT) break;
      n++;
      valleyIn = (n >= 2 && n <= 6);
    end
    valleyIn = 1'b0;
    check("R5 valley inside min off ignored", n, LF_MIN + LF_TO);
  endtask

  task automatic testRamp();
    int n;
    valleyIn = 1'b1;
    fbCode = 8'd90;
    lowAfterSettle(n);
    check("R3 ramp fb=90", n, 40 + VDLY + 1);
    fbCode = 8'd75;
    lowAfterSettle(n);
    check("R3 ramp fb=75", n, 70 + VDLY + 1);
    fbCode = 8'd62;
    lowAfterSettle(n);
    check("R3 ramp clamp above lower knee fb=62", n, LF_MAX + VDLY + 1);
    fbCode = 8'd50;
    lowAfterSettle(n);
    check("R3 below lower knee fb=50", n, LF_MAX + VDLY + 1);
  endtask

  task automatic testHysteresis();
    int n;
    valleyIn = 1'b1;
    fbCode = 8'd98;   // from light load: stays in it
    lowAfterSettle(n);
    check("R4 band kept from light load", n, 24 + VDLY + 1);
    fbCode = 8'd100;  // at upper knee: leaves
    lowAfterSettle(n);
    check("R4 exit at upper knee", n, LF_MIN + VDLY + 1);
    fbCode = 8'd98;   // from normal: stays normal
    lowAfterSettle(n);
    check("R4 band kept from normal", n, LF_MIN + VDLY + 1);
    fbCode = 8'd95;   // below entry level
    lowAfterSettle(n);
    check("R4 entry below band", n, 30 + VDLY + 1);
    fbCode = 8'd120;
  endtask

  task automatic testBlanking();
    int n;
    fbCode = 8'd120; valleyIn = 1'b1; csTripIn = 1'b1;
    measHigh(n);
    measHigh(n);
    check("R8 trip masked during blank", n, BLANK + 1);
    csTripIn = 1'b0;
    waitLevel(1'b0);
    waitLevel(1'b1);
    n = 1;
    forever begin
      if (n == 20) csTripIn = 1'b1;
      @(negedge clk);
      if (gateOut !== 1'b1 || n >= WAIT_LIMIT) break;
      n++;
    end
    csTripIn = 1'b0;
    check("R8 late trip ends pulse", n, 20);
  endtask

  task automatic testFault();
    int n;
    int highSeen = 0;
    fbCode = 8'd120; valleyIn = 1'b1; csTripIn = 1'b0;
    waitLevel(1'b1);
    faultIn = 1'b1;
    fbCode = 8'd50;
    #1;
    check("R10 gate drops with fault", int'(gateOut), 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gateOut !== 1'b0) highSeen++;
    end
    check("R10 gate held low during fault", highSeen, 0);
    faultIn = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (gateOut !== 1'b1 && n < WAIT_LIMIT);
    // release negedge excluded: off-time + valley delay + 1 negedges
    check("R10 full off-time after release", n, LF_MAX + VDLY + 1);
    fbCode = 8'd120;
  endtask

  task automatic testSelectIgnored();
    int n;
    hfSelIn = 1'b1;
    fbCode = 8'd120; valleyIn = 1'b1;
    lowAfterSettle(n);
    check("R1 select change after reset ignored", n, LF_MIN + VDLY + 1);
  endtask

  task automatic testHighFreq();
    int n;
    doReset(1'b1);
    hfSelIn = 1'b0;
    fbCode = 8'd120; valleyIn = 1'b1;
    lowAfterSettle(n);
    check("R11 HF floor with valley", n, HF_MIN + VDLY + 1);
    valleyIn = 1'b0;
    lowAfterSettle(n);
    check("R11 HF timeout", n, HF_MIN + HF_TO);
    valleyIn = 1'b1;
    fbCode = 8'd80;
    lowAfterSettle(n);
    check("R11 HF ramp fb=80", n, 30 + VDLY + 1);
    fbCode = 8'd50;
    lowAfterSettle(n);
    check("R11 HF ceiling", n, HF_MAX + VDLY + 1);
  endtask

  initial begin
    doReset(1'b0);
    testFloorAndValley();
    testTimeout();
    testEarlyValley();
    testRamp();
    testHysteresis();
    testBlanking();
    testFault();
    testSelectIgnored();
    testHighFreq();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule